// File: doc/BRIEF.md
# Data-Enable Row and Frame Timing Recovery

This block rebuilds the scan position of a flat panel from the pixel clock and one data-enable line. It needs no horizontal or vertical sync. A rising enable opens a row at column zero, and a falling enable closes that row. When the row closes, the block issues a strobe that tells the column storage to capture the row. It also advances the row index. A long quiet stretch on the enable line marks the end of a frame, so the next active stretch becomes row zero of a new frame. The row index also wraps back to the top after the last row. This wrap is a backup for the idle-gap rule.

If the enable stays active longer than a row can hold, the column counter runs past its limit. The block then advances the row on its own and sends no capture strobe. The column storage therefore keeps the previous data, and the panel shows that row again. The block may come out of reset in the middle of a running stream. In that case it does not assume it is at the top of the frame. It stays unsynchronised, and it emits no row or frame pulses until it has seen one idle gap that qualifies.

Panel width, panel height and the idle threshold are parameters. All outputs are registered, and each one reflects the enable value sampled at the previous clock edge.

Top module: `panel_de_timing`

## Requirements
- R1: The horizontal and vertical sync inputs have no effect on any output.
- R2: `pixValid` equals the enable sampled one clock earlier. `colIdx` is 0 for the first active sample of a row and rises by 1 for each further active sample. `colIdx` is 0 whenever `pixValid` is low.
- R3: On the first clock edge that samples the enable low after an active sample, `rowAdv` and `latchLoad` are both high for exactly one cycle, and `rowIdx` moves to the next row in that same cycle.
- R4: Suppose the enable was sampled low on more than `IDLE_LIMIT` consecutive edges and is then sampled high. On that edge `frameStart` pulses for one cycle, `rowIdx` becomes 0, `colIdx` becomes 0 and `synced` goes high.
- R5: After a gap of at most `IDLE_LIMIT` low samples, including a gap of exactly `IDLE_LIMIT`, the rising enable gives no `frameStart` and leaves `rowIdx` unchanged.
- R6: A row advance taken from row `ROWS-1` sets `rowIdx` to 0 and does not pulse `frameStart`.
- R7: Suppose the enable is sampled high at column `COLS-1` and again on the next edge. That edge gives a one-cycle `rowAdv` with `latchLoad` low, and `colIdx` restarts at 0. Counting then continues, so each further run of `COLS` samples repeats the forced advance.
- R8: From reset until the first qualifying gap of R4, `synced` stays low, `rowIdx` stays 0, and `rowAdv`, `latchLoad` and `frameStart` stay low. This holds even when the enable is already running when reset is released.
- R9: A row whose enable is high for a single sample still gives a normal `latchLoad` and `rowAdv` when the enable falls.
- R10: The idle counter stops at its top value instead of wrapping. An idle gap of any length above the threshold therefore still qualifies, for example 16 low samples with a threshold of 10 and a 4-bit counter.
- R11: A synchronous reset clears every output, `synced` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| de | input | 1 | Data-enable from the video source |
| hsyncIn | input | 1 | Horizontal sync, ignored |
| vsyncIn | input | 1 | Vertical sync, ignored |
| pixValid | output | 1 | Active-pixel strobe |
| colIdx | output | $clog2(COLS) | Column of the current pixel |
| rowIdx | output | $clog2(ROWS) | Current row |
| rowAdv | output | 1 | One-cycle row-advance pulse |
| latchLoad | output | 1 | One-cycle capture strobe for column storage |
| frameStart | output | 1 | One-cycle pulse at the first pixel of a frame |
| synced | output | 1 | High once a qualifying idle gap has been seen |

## Verification
The assertions assume that the enable input is sampled cleanly on the pixel clock. They also assume that reset is held for at least one edge, so that the edge detector and the counters start from a known state. They do not assume that the enable pattern looks like a real video timing. Short rows, single-sample rows, gaps close to the threshold and enables held far beyond a row are all legal. The stimulus changes the enable only on the falling clock edge, and it covers exactly these irregular shapes on purpose. It also toggles the sync inputs during both idle and active stretches.

// File: rtl/de_timing_pkg.sv
package de_timing_pkg;

  // Strobes handed from the control to the counter datapath each cycle.
  typedef struct packed {
    logic active;    // enable sampled high this edge
    logic rise;      // first active sample after an idle one
    logic fall;      // first idle sample after an active one
    logic overflow;  // active sample past the last column
    logic newFrame;  // rise that follows a qualifying idle gap
    logic synced;    // a qualifying gap has already been seen
  } timingStrobes_t;

endpackage

// File: rtl/de_timing_ctrl.sv
module de_timing_ctrl
  import de_timing_pkg::*;
#(
  parameter int IDLE_LIMIT = 3000,
  parameter int IDLE_W     = $clog2(IDLE_LIMIT + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           de,
  input  logic           colAtEnd,
  output timingStrobes_t strb
);

  localparam logic [IDLE_W-1:0] IDLE_TOP   = IDLE_W'(IDLE_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_THRESH = IDLE_W'(IDLE_LIMIT);

  logic              deQ;
  logic [IDLE_W-1:0] idleCnt;
  logic              syncedQ;
  logic              longGap;

  // Previous enable sample, used to find edges.
  always_ff @(posedge clk) begin
    if (rst) deQ <= 1'b0;
    else     deQ <= de;
  end

  // Idle counter: cleared while active, saturates one above the threshold.
  always_ff @(posedge clk) begin
    if (rst)                  idleCnt <= '0;
    else if (de)              idleCnt <= '0;
    else if (idleCnt != IDLE_TOP) idleCnt <= idleCnt + 1'b1;
  end

  assign longGap = (idleCnt > IDLE_THRESH);

  // Sticky frame lock, set by the first qualifying gap.
  always_ff @(posedge clk) begin
    if (rst)                 syncedQ <= 1'b0;
    else if (de && !deQ && longGap) syncedQ <= 1'b1;
  end

  always_comb begin
    strb.active   = de;
    strb.rise     = de & ~deQ;
    strb.fall     = ~de & deQ;
    strb.overflow = de & deQ & colAtEnd;
    strb.newFrame = de & ~deQ & longGap;
    strb.synced   = syncedQ;
  end

endmodule

// File: rtl/de_timing_counters.sv
module de_timing_counters
  import de_timing_pkg::*;
#(
  parameter int COLS  = 1024,
  parameter int ROWS  = 768,
  parameter int COL_W = $clog2(COLS),
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  timingStrobes_t   strb,
  output logic             colAtEnd,
  output logic             pixValid,
  output logic [COL_W-1:0] colIdx,
  output logic [ROW_W-1:0] rowIdx,
  output logic             rowAdv,
  output logic             latchLoad,
  output logic             frameStart
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] nextRow;
  logic             advance;

  assign colAtEnd = (colIdx == COL_LAST);
  assign nextRow  = (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;
  assign advance  = (strb.fall | strb.overflow) & strb.synced;

  // Column position, restarted on a new row or a forced advance.
  always_ff @(posedge clk) begin
    if (rst) begin
      pixValid <= 1'b0;
      colIdx   <= '0;
    end else begin
      pixValid <= strb.active;
      if (!strb.active)                     colIdx <= '0;
      else if (strb.rise || strb.overflow)  colIdx <= '0;
      else                                  colIdx <= colIdx + 1'b1;
    end
  end

  // Row position and the one-cycle strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rowIdx     <= '0;
      rowAdv     <= 1'b0;
      latchLoad  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      rowAdv     <= 1'b0;
      latchLoad  <= 1'b0;
      frameStart <= 1'b0;
      if (strb.newFrame) begin
        rowIdx     <= '0;
        frameStart <= 1'b1;
      end else if (advance) begin
        rowIdx    <= nextRow;
        rowAdv    <= 1'b1;
        latchLoad <= strb.fall;
      end
    end
  end

endmodule

// File: rtl/panel_de_timing.sv
module panel_de_timing
  import de_timing_pkg::*;
#(
  parameter int COLS       = 1024,
  parameter int ROWS       = 768,
  parameter int IDLE_LIMIT = 3000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     de,
  input  logic                     hsyncIn,
  input  logic                     vsyncIn,
  output logic                     pixValid,
  output logic [$clog2(COLS)-1:0]  colIdx,
  output logic [$clog2(ROWS)-1:0]  rowIdx,
  output logic                     rowAdv,
  output logic                     latchLoad,
  output logic                     frameStart,
  output logic                     synced
);

  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 2);

  timingStrobes_t strb;
  logic           colAtEnd;
  logic           syncUnused;

  // Sync inputs are accepted for pin compatibility and then discarded.
  assign syncUnused = hsyncIn ^ vsyncIn;

  de_timing_ctrl #(
    .IDLE_LIMIT(IDLE_LIMIT),
    .IDLE_W    (IDLE_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .de      (de),
    .colAtEnd(colAtEnd),
    .strb    (strb)
  );

  de_timing_counters #(
    .COLS (COLS),
    .ROWS (ROWS),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .colAtEnd  (colAtEnd),
    .pixValid  (pixValid),
    .colIdx    (colIdx),
    .rowIdx    (rowIdx),
    .rowAdv    (rowAdv),
    .latchLoad (latchLoad),
    .frameStart(frameStart)
  );

  assign synced = strb.synced;

endmodule

// File: rtl/de_timing_checker.sv
module de_timing_checker #(
  parameter int COLS = 1024,
  parameter int ROWS = 768
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pixValid,
  input logic [$clog2(COLS)-1:0] colIdx,
  input logic [$clog2(ROWS)-1:0] rowIdx,
  input logic                    rowAdv,
  input logic                    latchLoad,
  input logic                    frameStart,
  input logic                    synced
);

  // R2: consecutive active samples step the column by one unless restarted
  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pixValid && $past(pixValid) && colIdx != '0) |-> colIdx == $past(colIdx) + 1'b1);

  // R2: idle samples carry column 0
  p_col_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !pixValid |-> colIdx == '0);

  // R3: a capture strobe comes only at the end of an active run
  p_latch_fall_r3: assert property (@(posedge clk) disable iff (rst)
    latchLoad |-> (!pixValid && $past(pixValid)));

  // R3: every capture strobe is also a row advance
  p_latch_adv_r3: assert property (@(posedge clk) disable iff (rst)
    latchLoad |-> rowAdv);

  // R3, R6: an advance moves the row by one, wrapping at the bottom
  p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
    rowAdv |-> (int'(rowIdx) == ((int'($past(rowIdx)) == ROWS - 1) ? 0 : int'($past(rowIdx)) + 1)));

  // R4: a frame start lands on the top-left pixel with lock held
  p_frame_top_r4: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (pixValid && colIdx == '0 && rowIdx == '0 && synced));

  // R4: frame start and row advance never coincide
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frameStart, rowAdv}));

  // R7: an advance without capture happens mid-run at column 0
  p_forced_adv_r7: assert property (@(posedge clk) disable iff (rst)
    (rowAdv && !latchLoad) |-> (pixValid && $past(pixValid) && colIdx == '0));

  // R8: no pulses and row 0 before lock
  p_quiet_unsynced_r8: assert property (@(posedge clk) disable iff (rst)
    !synced |-> (!rowAdv && !latchLoad && !frameStart && rowIdx == '0));

  // R8: lock is released only by reset, and is gained only with a frame start
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(synced) |-> synced);

  p_lock_entry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(synced) |-> frameStart);

endmodule

bind panel_de_timing de_timing_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pixValid  (pixValid),
  .colIdx    (colIdx),
  .rowIdx    (rowIdx),
  .rowAdv    (rowAdv),
  .latchLoad (latchLoad),
  .frameStart(frameStart),
  .synced    (synced)
);

// File: tb/tb_panel_de_timing.sv
module tb_panel_de_timing;

  localparam int CLK_PERIOD = 10;
  localparam int COLS       = 8;
  localparam int ROWS       = 4;
  localparam int IDLE_LIMIT = 10;
  localparam int NV         = 26;

  // Result word: {pixValid, colIdx[2:0], rowIdx[1:0], rowAdv, latchLoad, frameStart, synced}
  typedef struct packed {
    logic [7:0] reps;
    logic       de;
    logic       sy;
    logic [9:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, 1'b0, 10'b1_001_00_0000, 4'd2},  // R2 columns before lock
    '{8'd1,  1'b0, 1'b0, 10'b0_000_00_0000, 4'd8},  // R8 fall before lock is silent
    '{8'd3,  1'b0, 1'b1, 10'b0_000_00_0000, 4'd1},  // R1 sync toggling while idle
    '{8'd1,  1'b1, 1'b0, 10'b1_000_00_0000, 4'd5},  // R5 gap of 4 is short
    '{8'd1,  1'b0, 1'b0, 10'b0_000_00_0000, 4'd8},  // R8 still silent
    '{8'd10, 1'b0, 1'b0, 10'b0_000_00_0000, 4'd8},  // R8 gap reaches 11
    '{8'd1,  1'b1, 1'b0, 10'b1_000_00_0011, 4'd4},  // R4 frame start and lock
    '{8'd7,  1'b1, 1'b1, 10'b1_111_00_0001, 4'd2},  // R2 full row, R1 sync toggling
    '{8'd1,  1'b0, 1'b0, 10'b0_000_01_1101, 4'd3},  // R3 fall latches
    '{8'd3,  1'b0, 1'b0, 10'b0_000_01_0001, 4'd3},  // R3 pulses last one cycle
    '{8'd1,  1'b1, 1'b0, 10'b1_000_01_0001, 4'd5},  // R5 short gap keeps row
    '{8'd1,  1'b0, 1'b0, 10'b0_000_10_1101, 4'd9},  // R9 one-sample row latches
    '{8'd2,  1'b0, 1'b0, 10'b0_000_10_0001, 4'd3},  // R3
    '{8'd1,  1'b1, 1'b0, 10'b1_000_10_0001, 4'd2},  // R2
    '{8'd7,  1'b1, 1'b0, 10'b1_111_10_0001, 4'd2},  // R2 last column
    '{8'd1,  1'b1, 1'b0, 10'b1_000_11_1001, 4'd7},  // R7 forced advance, no latch
    '{8'd7,  1'b1, 1'b0, 10'b1_111_11_0001, 4'd7},  // R7 counting resumes
    '{8'd1,  1'b1, 1'b0, 10'b1_000_00_1001, 4'd6},  // R6 wrap on second overflow
    '{8'd1,  1'b1, 1'b0, 10'b1_001_00_0001, 4'd7},  // R7 column after restart
    '{8'd1,  1'b0, 1'b0, 10'b0_000_01_1101, 4'd3},  // R3
    '{8'd16, 1'b0, 1'b1, 10'b0_000_01_0001, 4'd10}, // R10 gap of 16
    '{8'd1,  1'b1, 1'b0, 10'b1_000_00_0011, 4'd10}, // R10 still qualifies
    '{8'd1,  1'b0, 1'b0, 10'b0_000_01_1101, 4'd3},  // R3
    '{8'd9,  1'b0, 1'b0, 10'b0_000_01_0001, 4'd5},  // R5 gap of exactly 10
    '{8'd1,  1'b1, 1'b0, 10'b1_000_01_0001, 4'd5},  // R5 boundary: no frame
    '{8'd1,  1'b0, 1'b0, 10'b0_000_10_1101, 4'd3}   // R3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       de = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       vsyncIn = 1'b0;
  logic       pixValid;
  logic [2:0] colIdx;
  logic [1:0] rowIdx;
  logic       rowAdv;
  logic       latchLoad;
  logic       frameStart;
  logic       synced;

  int  vectors     = 0;
  int  miscompares = 0;
  bit  done        = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  panel_de_timing #(
    .COLS      (COLS),
    .ROWS      (ROWS),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .de        (de),
    .hsyncIn   (hsyncIn),
    .vsyncIn   (vsyncIn),
    .pixValid  (pixValid),
    .colIdx    (colIdx),
    .rowIdx    (rowIdx),
    .rowAdv    (rowAdv),
    .latchLoad (latchLoad),
    .frameStart(frameStart),
    .synced    (synced)
  );

  function automatic logic [9:0] observed();
    return {pixValid, colIdx, rowIdx, rowAdv, latchLoad, frameStart, synced};
  endfunction

  task automatic check(input logic [9:0] exp, input int req, input string what);
    vectors++;
    if (observed() !== exp) begin
      miscompares++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, observed(), exp);
    end
  endtask

  // Drive on the falling edge, sample just after the rising edge.
  task automatic step(input logic val, input logic toggleSync, input int k);
    @(negedge clk);
    de = val;
    if (toggleSync) begin
      hsyncIn = ~hsyncIn;
      vsyncIn = k[0];
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit seenAdv;
    repeat (3) @(posedge clk);
    #1;
    check(10'b0, 11, "outputs after reset");              // R11
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i].reps); k++) step(VEC[i].de, VEC[i].sy, k);
      check(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R11: reset from a locked state while the enable is running
    @(negedge clk);
    de  = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check(10'b0, 11, "reset clears lock mid-stream");

    // R8: release reset with the enable already high
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(10'b1_000_00_0000, 8, "mid-stream start is not a frame");

    // R8: an overlong run before lock gives no advance
    seenAdv = 1'b0;
    for (int k = 0; k < 12; k++) begin
      step(1'b1, 1'b0, k);
      if (rowAdv || latchLoad || frameStart) seenAdv = 1'b1;
    end
    check(10'b1_100_00_0000, 8, "overlong run before lock");
    vectors++;
    if (seenAdv) begin
      miscompares++;
      $display("FAIL R8 pulse before lock: actual=1 expected=0");
    end
    step(1'b0, 1'b0, 0);
    check(10'b0, 8, "fall before lock after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule